// File: doc/BRIEF.md
# Supply Undervoltage and Thermal Fault Supervisor

This block watches the health of a small multi-rail power controller. It takes one digital "within limits" flag for each of four regulated outputs and one for the monitored main input supply. It also takes two over-temperature comparator levels, a warning level and a shutdown level. From these it drives a single fault line, a turn-off request for each regulator, and a request to the state sequencer to drop into the forced soft-off state. Each voltage flag must stay low for a set number of clock cycles before it counts, and a monitor that the sequencer has not yet enabled is ignored.

The response depends on the kind of rail. Outputs driven through an on-chip pass element (output 0 and output 1 by default) are latched off alone when they fail. Outputs driven through an external pass device only raise the fault line. During power-up, before the sequencer reports that the second soft-start ramp has ended, a failure on either standby output (output 0 and output 2 by default) latches the whole block off. A hard thermal trip does the same. Only power-on reset clears these two global latches. An external shutdown request turns every output off, forces the fault line low and clears the per-regulator latches, but it cannot clear a global latch.

Top module: `fault_supervisor`

## Requirements
- R1: After power-on reset `faultOut` is 0, `regOff` is all zeros and `softOffReq` is 0.
- R2: A monitor reports undervoltage only after its flag has been sampled low on TIMEOUT consecutive clock edges while enabled. `faultOut` rises after the TIMEOUT-th such edge. A shorter dip produces no fault and restarts the count.
- R3: A monitor whose `monEn` bit is 0 never reports, however long its flag stays low.
- R4: A confirmed undervoltage on an output with an external pass device (bits clear in INTERNAL_MASK) raises `faultOut` only while the flag stays low. It sets no `regOff` bit and leaves nothing latched.
- R5: A confirmed undervoltage on an output with an internal pass device (bit set in INTERNAL_MASK) raises `faultOut` and, one edge later, sets only that output's `regOff` bit. Both stay set after the flag recovers.
- R6: While `startDone` is 0, a confirmed undervoltage on an output whose bit is set in STARTUP_MASK sets all `regOff` bits and holds `faultOut` high, beginning one edge after confirmation. Only power-on reset clears this state.
- R7: `tempWarn` high raises `faultOut` while it is high and turns nothing off.
- R8: `tempShut` high on any edge sets all `regOff` bits and holds `faultOut` high until power-on reset, even after `tempShut` falls.
- R9: While `sdReq` is 1, all `regOff` bits are 1 and `faultOut` is 0, unless a global latch is set. The undervoltage filters are cleared, and any per-regulator latch is cleared, so that `regOff` returns to 0 after release.
- R10: `sdReq` does not clear the startup or thermal global latch. `faultOut` stays 1 and `regOff` stays all ones during and after the request.
- R11: A confirmed main-input undervoltage (monitor index NUM_OUT) raises `faultOut`. If `isActive` is 1, it also sets `softOffReq` one edge after confirmation. `softOffReq` then holds, regardless of `isActive`, until an edge sees the main flag high or `sdReq` high. A main-input undervoltage while `isActive` is 0 sets no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| monOk | input | NUM_OUT+1 | Per-monitor within-limits flags. Bits 0..NUM_OUT-1 are outputs and bit NUM_OUT is the main input |
| monEn | input | NUM_OUT+1 | Per-monitor enables from the sequencer |
| tempWarn | input | 1 | Over-temperature warning comparator level |
| tempShut | input | 1 | Over-temperature shutdown comparator level |
| sdReq | input | 1 | External shutdown request, active high |
| startDone | input | 1 | High once the second soft-start ramp has ended |
| isActive | input | 1 | High while the system is in an active power state |
| faultOut | output | 1 | Combined fault indication |
| regOff | output | NUM_OUT | Per-regulator turn-off request |
| softOffReq | output | 1 | Request to enter the forced soft-off state |

## Verification
The hardest situations to reach from the ports are the latch interactions. One is a global latch that must survive a shutdown request. Another is a per-regulator latch that must vanish under one. Both exist only after a fully filtered undervoltage has been confirmed in the right startup phase. The bench sweeps every monitor across enabled and disabled, startup window open and closed, active and inactive, and low durations from one cycle to past the timeout. For each case it computes the expected cycle of confirmation and latching. Directed sequences then build each latch and apply the shutdown request, a dropped active state, or a thermal trip on top of it.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  // strobes sent from control to the filter datapath
  typedef struct packed {
    logic flushAll;
  } filtStrobe_t;
endpackage

// File: rtl/fsup_filter.sv
module fsup_filter #(
  parameter int NUM_MON = 5,
  parameter int TIMEOUT = 1250
) (
  input  logic                    clk,
  input  logic                    porN,
  input  logic [NUM_MON-1:0]      monOk,
  input  logic [NUM_MON-1:0]      monEn,
  input  fsup_pkg::filtStrobe_t   strobe,
  output logic [NUM_MON-1:0]      uvHit
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  for (genvar g = 0; g < NUM_MON; g++) begin : gMon
    logic [CNT_W-1:0] lowCnt;

    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        lowCnt <= '0;
      end else if (strobe.flushAll || !monEn[g] || monOk[g]) begin
        lowCnt <= '0;
      end else if (lowCnt != LIMIT) begin
        lowCnt <= lowCnt + 1'b1;
      end
    end

    assign uvHit[g] = (lowCnt == LIMIT);

    // disabled monitor is silent on the following cycle
    assert_quiet_when_disabled_R3: assert property (@(posedge clk) disable iff (!porN)
      !monEn[g] |=> !uvHit[g]);
    // a report only appears after a low sample
    assert_hit_after_low_R2: assert property (@(posedge clk) disable iff (!porN)
      $rose(uvHit[g]) |-> !$past(monOk[g]));
  end
endmodule

// File: rtl/fsup_ctrl.sv
module fsup_ctrl #(
  parameter int NUM_OUT = 4,
  parameter logic [NUM_OUT-1:0] INTERNAL_MASK = 4'b0011,
  parameter logic [NUM_OUT-1:0] STARTUP_MASK  = 4'b0101
) (
  input  logic                  clk,
  input  logic                  porN,
  input  logic [NUM_OUT:0]      uvHit,
  input  logic                  mainOk,
  input  logic                  tempWarn,
  input  logic                  tempShut,
  input  logic                  sdReq,
  input  logic                  startDone,
  input  logic                  isActive,
  output fsup_pkg::filtStrobe_t strobe,
  output logic                  faultOut,
  output logic [NUM_OUT-1:0]    regOff,
  output logic                  softOffReq
);
  localparam int MAIN = NUM_OUT;

  logic [NUM_OUT-1:0] outHit;
  logic               mainHit;
  logic               startTrip;
  logic               startLatch;
  logic               thermLatch;
  logic [NUM_OUT-1:0] regLatch;
  logic               hardLatch;
  logic               allOff;

  assign outHit    = uvHit[NUM_OUT-1:0];
  assign mainHit   = uvHit[MAIN];
  assign startTrip = (|(outHit & STARTUP_MASK)) && !startDone;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      startLatch <= 1'b0;
      thermLatch <= 1'b0;
      regLatch   <= '0;
      softOffReq <= 1'b0;
    end else begin
      startLatch <= startLatch | (startTrip & !sdReq);
      thermLatch <= thermLatch | tempShut;
      if (sdReq) regLatch <= '0;
      else       regLatch <= regLatch | (outHit & INTERNAL_MASK);
      if (sdReq || mainOk)          softOffReq <= 1'b0;
      else if (mainHit && isActive) softOffReq <= 1'b1;
    end
  end

  assign hardLatch       = startLatch | thermLatch;
  assign allOff          = hardLatch | sdReq;
  assign regOff          = regLatch | {NUM_OUT{allOff}};
  assign strobe.flushAll = sdReq;
  assign faultOut        = hardLatch |
                           (!sdReq & ((|uvHit) | tempWarn | (|regLatch)));

  assert_startup_hold_R6: assert property (@(posedge clk) disable iff (!porN)
    startLatch |=> startLatch);
  assert_thermal_hold_R8: assert property (@(posedge clk) disable iff (!porN)
    thermLatch |=> (thermLatch && faultOut));
  assert_sd_quiet_R9: assert property (@(posedge clk) disable iff (!porN)
    (sdReq && !hardLatch) |-> (!faultOut && (&regOff)));
  assert_ext_no_latch_R4: assert property (@(posedge clk) disable iff (!porN)
    (!sdReq && !hardLatch) |-> ((regOff & ~INTERNAL_MASK) == '0));
  assert_softoff_needs_active_R11: assert property (@(posedge clk) disable iff (!porN)
    $rose(softOffReq) |-> $past(isActive));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int NUM_OUT = 4,
  parameter int TIMEOUT = 1250,
  parameter logic [NUM_OUT-1:0] INTERNAL_MASK = 4'b0011,
  parameter logic [NUM_OUT-1:0] STARTUP_MASK  = 4'b0101
) (
  input  logic               clk,
  input  logic               porN,
  input  logic [NUM_OUT:0]   monOk,
  input  logic [NUM_OUT:0]   monEn,
  input  logic               tempWarn,
  input  logic               tempShut,
  input  logic               sdReq,
  input  logic               startDone,
  input  logic               isActive,
  output logic               faultOut,
  output logic [NUM_OUT-1:0] regOff,
  output logic               softOffReq
);
  localparam int NUM_MON = NUM_OUT + 1;

  fsup_pkg::filtStrobe_t strobe;
  logic [NUM_MON-1:0]    uvHit;

  fsup_filter #(.NUM_MON(NUM_MON), .TIMEOUT(TIMEOUT)) uFilter (
    .clk(clk), .porN(porN), .monOk(monOk), .monEn(monEn),
    .strobe(strobe), .uvHit(uvHit)
  );

  fsup_ctrl #(.NUM_OUT(NUM_OUT), .INTERNAL_MASK(INTERNAL_MASK),
              .STARTUP_MASK(STARTUP_MASK)) uCtrl (
    .clk(clk), .porN(porN), .uvHit(uvHit), .mainOk(monOk[NUM_OUT]),
    .tempWarn(tempWarn), .tempShut(tempShut), .sdReq(sdReq),
    .startDone(startDone), .isActive(isActive), .strobe(strobe),
    .faultOut(faultOut), .regOff(regOff), .softOffReq(softOffReq)
  );
endmodule

// File: tb/fault_supervisor_test.sv
module fault_supervisor_test;
  localparam int N = 4;
  localparam int T = 4;
  localparam logic [N-1:0] INT_M = 4'b0011;
  localparam logic [N-1:0] ST_M  = 4'b0101;

  logic clk = 1'b0;
  logic porN;
  logic [N:0] monOk, monEn;
  logic tempWarn, tempShut, sdReq, startDone, isActive;
  logic faultOut, softOffReq;
  logic [N-1:0] regOff;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fault_supervisor #(.NUM_OUT(N), .TIMEOUT(T), .INTERNAL_MASK(INT_M),
                     .STARTUP_MASK(ST_M)) uut (
    .clk(clk), .porN(porN), .monOk(monOk), .monEn(monEn),
    .tempWarn(tempWarn), .tempShut(tempShut), .sdReq(sdReq),
    .startDone(startDone), .isActive(isActive), .faultOut(faultOut),
    .regOff(regOff), .softOffReq(softOffReq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic checkAll(string req, logic f, logic [N-1:0] r, logic s);
    check({req, " faultOut"}, 32'(faultOut), 32'(f));
    check({req, " regOff"}, 32'(regOff), 32'(r));
    check({req, " softOffReq"}, 32'(softOffReq), 32'(s));
  endtask

  task automatic doReset();
    monOk = '1; monEn = '1; tempWarn = 0; tempShut = 0; sdReq = 0;
    startDone = 1; isActive = 1;
    porN = 0;
    step();
    porN = 1;
    step();
  endtask

  // one sweep trial: hold a flag low for len edges, then restore it
  task automatic trial(int idx, bit en, int len, bit sd, bit act);
    bit isInt, isSt, hit, lat;
    logic [N-1:0] expR;
    string tag;
    doReset();
    startDone = sd; isActive = act;
    monEn[idx] = en;
    monOk[idx] = 1'b0;
    isInt = (idx < N) && INT_M[idx];
    isSt  = (idx < N) && ST_M[idx] && !sd;
    if (!en)            tag = "R3";
    else if (idx == N)  tag = "R11";
    else if (isSt)      tag = "R6";
    else if (isInt)     tag = "R5";
    else                tag = "R4";
    for (int k = 1; k <= len; k++) begin
      step();
      hit = en && (k >= T);
      lat = en && (k >= T + 1);
      expR = isSt && lat ? '1 : (isInt && lat ? N'(1 << idx) : '0);
      checkAll($sformatf("%s/R2 idx%0d k%0d", tag, idx, k), hit, expR,
               (idx == N) && act && lat);
    end
    monOk[idx] = 1'b1;
    step();
    lat  = en && (len >= T);
    expR = isSt && lat ? '1 : (isInt && lat ? N'(1 << idx) : '0);
    checkAll($sformatf("%s release idx%0d len%0d", tag, idx, len),
             lat && (isInt || isSt), expR, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    doReset();
    checkAll("R1 reset", 1'b0, '0, 1'b0);

    // sweep all monitors, enables, durations, startup phase, active state
    for (int idx = 0; idx <= N; idx++)
      for (int en = 0; en < 2; en++)
        for (int len = 1; len <= T + 2; len++)
          for (int sd = 0; sd < 2; sd++)
            for (int act = 0; act < 2; act++)
              if (act == 1 || idx == N) trial(idx, en[0], len, sd[0], act[0]);

    // short dip then restart of count
    doReset();
    monOk[3] = 0; step(); step(); monOk[3] = 1; step();
    monOk[3] = 0; step(); step(); step();
    checkAll("R2 restart", 1'b0, '0, 1'b0);
    step();
    checkAll("R2 restart confirm", 1'b1, '0, 1'b0);

    // warning temperature
    doReset();
    tempWarn = 1; step();
    checkAll("R7 warn", 1'b1, '0, 1'b0);
    tempWarn = 0; step();
    checkAll("R7 warn gone", 1'b0, '0, 1'b0);

    // thermal shutdown sticky, not cleared by sdReq
    doReset();
    tempShut = 1; step();
    checkAll("R8 trip", 1'b1, '1, 1'b0);
    tempShut = 0; step(); step();
    checkAll("R8 held", 1'b1, '1, 1'b0);
    sdReq = 1; step();
    checkAll("R10 thermal sd", 1'b1, '1, 1'b0);
    sdReq = 0; step();
    checkAll("R10 thermal after sd", 1'b1, '1, 1'b0);
    doReset();
    checkAll("R1 thermal cleared", 1'b0, '0, 1'b0);

    // startup latch survives sdReq
    doReset();
    startDone = 0; monOk[2] = 0;
    for (int k = 0; k < T + 1; k++) step();
    monOk[2] = 1; startDone = 1; step();
    checkAll("R6 startup held", 1'b1, '1, 1'b0);
    sdReq = 1; step();
    checkAll("R10 startup sd", 1'b1, '1, 1'b0);
    sdReq = 0; step();
    checkAll("R10 startup after sd", 1'b1, '1, 1'b0);

    // per-regulator latch cleared by sdReq
    doReset();
    monOk[1] = 0;
    for (int k = 0; k < T + 1; k++) step();
    monOk[1] = 1; step();
    checkAll("R5 held", 1'b1, 4'b0010, 1'b0);
    sdReq = 1; step();
    checkAll("R9 sd active", 1'b0, '1, 1'b0);
    sdReq = 0; step();
    checkAll("R9 sd released", 1'b0, '0, 1'b0);

    // soft-off request holds after active drops, cleared by sdReq
    doReset();
    monOk[N] = 0;
    for (int k = 0; k < T + 1; k++) step();
    checkAll("R11 request", 1'b1, '0, 1'b1);
    isActive = 0; step();
    checkAll("R11 hold inactive", 1'b1, '0, 1'b1);
    sdReq = 1; step();
    checkAll("R11 sd clears", 1'b0, '1, 1'b0);
    sdReq = 0;
    for (int k = 0; k < T; k++) step();
    checkAll("R11 inactive no request", 1'b1, '0, 1'b0);
    step();
    checkAll("R11 inactive still none", 1'b1, '0, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule